// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block sends one 8-bit PCM word per frame on a serial data output that can be released (high-impedance), with a timeslot indicator that is active while the output drives. The transmit bit clock and frame sync are asynchronous to the fast system clock. Each is passed through a synchronizer, and its rising and falling edges are found by edge detection at system-clock rate. The block measures how many bit-clock falling edges occur while the frame sync is high and classifies each frame sync as short (one bit period) or long (three or more bit periods). The result is held on a status output, which the receive port also uses.

A word is written into a holding register with a load strobe. It is copied into the shift register at the rising edge of frame sync, so a load during a frame takes effect in the next frame. Transmit-enable comes from the mode controller. While it is low, the serial output is not driven.

The sequencer has four states:
- IDLE: output released.
- ARMED: short format; frame sync has been captured and the block waits for the next bit-clock rise.
- DRIVE: shifting bits out.
- TAIL: long format; all eight bits are sent but frame sync is still high.

Transitions:
- IDLE->DRIVE: long start, when frame sync and bit clock are both high.
- IDLE->ARMED: short capture, on a bit-clock fall with frame sync high.
- ARMED->DRIVE: on a bit-clock rise.
- DRIVE->IDLE: at the eighth fall.
- DRIVE->TAIL: at the eighth fall while long format is selected and frame sync is still high.
- TAIL->IDLE: at frame-sync fall.
- Any state->IDLE: when transmit-enable is low.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, dout_en, slot_active, dout and long_fmt are all 0. long_fmt 0 means short format.
- R2: At each frame-sync fall, long_fmt is updated. It becomes 1 if two or more bit-clock falls occurred while frame sync was high (a pulse of three or more periods), and 0 otherwise (a one-period pulse). The new value applies from the next frame on.
- R3: With long_fmt = 1, the output starts driving, with the sign bit, once frame sync and bit clock are both high.
- R4: With long_fmt = 0, frame sync is captured on a bit-clock fall. The output starts driving, with the sign bit, at the next bit-clock rise.
- R5: Bits leave most significant first (word bit 7 first). Each of the next seven bit-clock rises presents the next lower bit.
- R6: In short format, the output is released at the eighth bit-clock fall after it was enabled.
- R7: In long format, the output is released at the later of the eighth bit-clock fall and the frame-sync fall. The last bit is held until then.
- R8: slot_active equals dout_en at all times.
- R9: The word sent is the one held at the frame-sync rise. A load during the frame changes only the next frame's word.
- R10: While tx_en is 0, dout_en and slot_active stay 0 for a whole frame.
- R11: dout reads 0 whenever dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable from the mode controller |
| bclk | input | 1 | Transmit bit clock (asynchronous) |
| fsync | input | 1 | Transmit frame sync (asynchronous) |
| word_in | input | 8 | PCM word to send |
| word_load | input | 1 | Strobe writing word_in into the holding register |
| dout | output | 1 | Serial data, valid while dout_en is 1 |
| dout_en | output | 1 | Drive enable for the serial output |
| slot_active | output | 1 | Timeslot indicator |
| long_fmt | output | 1 | Detected format: 1 long, 0 short |

## Verification
The assertions assume that each bit-clock phase spans several system clocks, so that every edge is seen once, in order, after the synchronizer. They also assume that frame sync changes only together with a bit-clock rise, so a frame-sync fall never coincides with a bit-clock fall. The stimulus respects both conditions:
- Bit clock and frame sync are driven only on system-clock falling edges.
- Every bit-clock half-period lasts eight system clocks.
- Frame-sync transitions are placed at the start of a bit-clock high phase.

Under these conditions, the output may start only while the bit clock is high, may change value only just after a bit-clock rise, and may be released only just after a bit-clock fall or a frame-sync fall.

// File: rtl/pcmtx_pkg.sv
package pcmtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DRIVE,
        ST_TAIL
    } tx_state_t;
endpackage

// File: rtl/pcmtx_edge.sv
// Multi-stage synchronizer followed by a single-cycle edge detector.
module pcmtx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/pcmtx_fmt.sv
// Counts bit-clock falls inside the frame-sync pulse; classifies at its fall.
module pcmtx_fmt #(
    parameter int CNT_W    = 3,
    parameter int LONG_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_lvl,
    input  logic fs_rise,
    input  logic fs_fall,
    input  logic b_fall,
    output logic long_fmt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(LONG_MIN);

    logic [CNT_W-1:0] falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            falls    <= '0;
            long_fmt <= 1'b0;
        end else begin
            if (fs_rise)
                falls <= '0;
            else if (fs_lvl && b_fall && falls != CNT_MAX)
                falls <= falls + 1'b1;
            if (fs_fall)
                long_fmt <= (falls >= CNT_THR);
        end
    end
endmodule

// File: rtl/pcmtx_fsm.sv
// Slot sequencer with word holding register and shift register.
module pcmtx_fsm
    import pcmtx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         long_fmt,
    input  logic         fs_lvl,
    input  logic         fs_rise,
    input  logic         b_lvl,
    input  logic         b_rise,
    input  logic         b_fall,
    input  logic [W-1:0] word_in,
    input  logic         word_load,
    output logic         dout,
    output logic         dout_en
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    tx_state_t     state, nxt;
    logic [W-1:0]  hold, shreg;
    logic [CW-1:0] bitcnt;
    logic          armed;
    logic          fresh;

    assign fresh = armed | fs_rise;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (fs_lvl && fresh) begin
                    if (long_fmt && b_lvl)
                        nxt = ST_DRIVE;          // long start
                    else if (!long_fmt && b_fall)
                        nxt = ST_ARMED;          // short capture
                end
            end
            ST_ARMED: if (b_rise) nxt = ST_DRIVE;
            ST_DRIVE: begin
                if (b_fall && bitcnt == LAST)
                    nxt = (long_fmt && fs_lvl) ? ST_TAIL : ST_IDLE;
            end
            ST_TAIL:  if (!fs_lvl) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
        if (!tx_en) nxt = ST_IDLE;
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hold   <= '0;
            shreg  <= '0;
            bitcnt <= '0;
            armed  <= 1'b0;
        end else begin
            state <= nxt;
            if (word_load)
                hold <= word_in;
            if (!tx_en || (state == ST_IDLE && nxt != ST_IDLE))
                armed <= 1'b0;
            else if (fs_rise)
                armed <= 1'b1;
            if (state == ST_IDLE && fs_rise)
                shreg <= hold;
            else if (state == ST_DRIVE && b_rise && bitcnt != LAST)
                shreg <= {shreg[W-2:0], 1'b0};
            if (state != ST_DRIVE)
                bitcnt <= '0;
            else if (b_rise && bitcnt != LAST)
                bitcnt <= bitcnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        dout_en = 1'b0;
        dout    = 1'b0;
        unique case (state)
            ST_DRIVE, ST_TAIL: begin
                dout_en = 1'b1;
                dout    = shreg[W-1];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FS_CNT_W    = 3,
    parameter int LONG_FALLS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bclk,
    input  logic              fsync,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_load,
    output logic              dout,
    output logic              dout_en,
    output logic              slot_active,
    output logic              long_fmt
);
    logic b_lvl, b_rise, b_fall;
    logic fs_lvl, fs_rise, fs_fall;

    pcmtx_edge #(.STAGES(SYNC_STAGES)) u_bclk (
        .clk(clk), .rst_n(rst_n), .din(bclk),
        .lvl(b_lvl), .rise(b_rise), .fall(b_fall)
    );

    pcmtx_edge #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst_n(rst_n), .din(fsync),
        .lvl(fs_lvl), .rise(fs_rise), .fall(fs_fall)
    );

    pcmtx_fmt #(.CNT_W(FS_CNT_W), .LONG_MIN(LONG_FALLS)) u_fmt (
        .clk(clk), .rst_n(rst_n), .fs_lvl(fs_lvl), .fs_rise(fs_rise),
        .fs_fall(fs_fall), .b_fall(b_fall), .long_fmt(long_fmt)
    );

    pcmtx_fsm #(.W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .long_fmt(long_fmt),
        .fs_lvl(fs_lvl), .fs_rise(fs_rise), .b_lvl(b_lvl),
        .b_rise(b_rise), .b_fall(b_fall), .word_in(word_in),
        .word_load(word_load), .dout(dout), .dout_en(dout_en)
    );

    assign slot_active = dout_en;
endmodule

// File: rtl/pcmtx_checker.sv
module pcmtx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic b_lvl,
    input logic b_rise,
    input logic b_fall,
    input logic fs_fall,
    input logic dout,
    input logic dout_en,
    input logic long_fmt
);
    // R10: transmit disabled releases the output on the next cycle
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !dout_en);

    // R3 / R4: the output only starts while the bit clock is high
    assert_start_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(b_lvl));

    // R5: serial data changes only just after a bit-clock rise
    assert_shift_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en) && !$past(b_rise)) |-> $stable(dout));

    // R6 / R7: release follows a bit-clock fall or a frame-sync fall
    assert_release_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dout_en) && $past(tx_en)) |-> ($past(b_fall) || $past(fs_fall)));

    // R2: format status moves only after a frame-sync fall
    assert_fmt_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_fmt) |-> $past(fs_fall));
endmodule

bind pcm_tx_port pcmtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .b_lvl(b_lvl),
    .b_rise(b_rise), .b_fall(b_fall), .fs_fall(fs_fall),
    .dout(dout), .dout_en(dout_en), .long_fmt(long_fmt)
);

// File: tb/tb_pcm_tx_port.sv
module tb_pcm_tx_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_en, bclk, fsync, word_load;
    logic [7:0] word_in;
    logic       dout, dout_en, slot_active, long_fmt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic  en;
        logic  bv;
        string tag;
    } exp_t;

    exp_t q[$];
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_tx_port dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk(bclk), .fsync(fsync),
        .word_in(word_in), .word_load(word_load), .dout(dout),
        .dout_en(dout_en), .slot_active(slot_active), .long_fmt(long_fmt)
    );

    task automatic chk1(input logic act, input logic expv, input string tag, input string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk1(dout_en, e.en, e.tag, "dout_en");
                chk1(slot_active, e.en, e.tag, "slot_active (R8)");
                chk1(dout, e.en ? e.bv : 1'b0, e.tag, "dout (R11 when released)");
            end
        end
    end

    // one bit-clock half period; an expectation is checked mid-phase
    task automatic phase(input logic b, input logic f, input logic en, input logic bv, input string tag);
        @(negedge clk);
        bclk  = b;
        fsync = f;
        repeat (4) @(negedge clk);
        q.push_back('{en, bv, tag});
        -> mon_ev;
        repeat (HALF_CLKS - 5) @(negedge clk);
    endtask

    task automatic load_word(input logic [7:0] w);
        @(negedge clk);
        word_in   = w;
        word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
    endtask

    // driver: one frame plus a trailing idle bit period
    task automatic frame(input logic [7:0] w, input bit lng, input int fs_len, input bit sends,
                         input bit mid, input logic [7:0] mw, input string tag);
        int n;
        n = lng ? 8 : 9;
        if (fs_len > n) n = fs_len;
        for (int p = 0; p < n; p++) begin
            logic f, eh, el, bh;
            f = (p < fs_len);
            if (lng) begin
                bh = w[7 - ((p > 7) ? 7 : p)];
                eh = 1'b1;
                el = (p < 7) || f;
            end else begin
                eh = (p >= 1);
                el = (p >= 1) && (p < 8);
                bh = (p >= 1 && p <= 8) ? w[8 - p] : 1'b0;
            end
            if (!sends) begin
                eh = 1'b0;
                el = 1'b0;
            end
            if (mid && p == 3) load_word(mw);
            phase(1'b1, f, eh, bh, tag);
            phase(1'b0, f, el, bh, tag);
        end
        phase(1'b1, 1'b0, 1'b0, 1'b0, tag);
        phase(1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        rst_n = 1'b0; tx_en = 1'b1; bclk = 1'b0; fsync = 1'b0;
        word_load = 1'b0; word_in = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk1(dout_en, 1'b0, "R1", "dout_en after reset");
        chk1(slot_active, 1'b0, "R1", "slot_active after reset");
        chk1(dout, 1'b0, "R1", "dout after reset");
        chk1(long_fmt, 1'b0, "R1", "long_fmt after reset");
        phase(1'b1, 1'b0, 1'b0, 1'b0, "R1 idle");
        phase(1'b0, 1'b0, 1'b0, 1'b0, "R1 idle");

        load_word(8'hA5);
        frame(8'hA5, 1'b0, 1, 1'b1, 1'b0, 8'h00, "R4 R5 R6 short frame");
        chk1(long_fmt, 1'b0, "R2", "one-period pulse keeps short");

        load_word(8'h3C);
        frame(8'h3C, 1'b0, 3, 1'b1, 1'b0, 8'h00, "R4 R6 short timing, long pulse");
        chk1(long_fmt, 1'b1, "R2", "three-period pulse selects long");

        load_word(8'h96);
        frame(8'h96, 1'b1, 3, 1'b1, 1'b0, 8'h00, "R3 R5 R7 long frame");
        chk1(long_fmt, 1'b1, "R2", "long stays long");

        load_word(8'h81);
        frame(8'h81, 1'b1, 11, 1'b1, 1'b0, 8'h00, "R7 frame sync outlasts word");

        load_word(8'h5A);
        frame(8'h5A, 1'b1, 1, 1'b1, 1'b1, 8'hC3, "R9 load during frame");
        chk1(long_fmt, 1'b0, "R2", "short pulse returns to short");

        frame(8'hC3, 1'b0, 1, 1'b1, 1'b0, 8'h00, "R9 next frame uses new word");

        @(negedge clk) tx_en = 1'b0;
        load_word(8'hFF);
        frame(8'hFF, 1'b0, 1, 1'b0, 1'b0, 8'h00, "R10 transmit disabled");
        @(negedge clk) tx_en = 1'b1;
        frame(8'hFF, 1'b0, 1, 1'b1, 1'b0, 8'h00, "R10 re-enabled");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule